// File: doc/BRIEF.md
# Legacy System I/O Register Block

This block holds the byte-wide control and status ports of an older PC-style system board. The requester issues single-cycle reads and writes to a 16-bit I/O port address. Some writes drive level outputs directly: a CPU soft-reset line, a sticky halt flag raised when the unsupported little-endian byte order is requested, and a non-contiguous I/O map select. Two read/write registers hold system control and I/O map type. Two read-only bytes, the equipment byte and the board identity byte, come from parameters. A group of write-only sink ports accepts writes and does nothing with them. A keylock port always reads zero.

A separate 32-bit memory window answers at one word address with a parity-error status of zero. Only full-word accesses are legal there. Any narrower access raises an access-error pulse.

Request channels carry a valid strobe and have no ready. The block accepts a request in every cycle, so it applies no back-pressure. Each read answers exactly one cycle later with a response valid strobe, and the requester must take that response in that cycle; the response path cannot stall. Bits of a port byte are numbered with bit 0 as the most significant, so bit n is mask 1<<(7-n).

Top module: `sysio_regblk`

## Requirements
- R1: Synchronous active-high `rst` clears the system control and map type registers to 0x00 and drives `soft_reset_o`, `le_halt_o`, `noncontig_map_o`, `io_rvalid`, `mem_rvalid` and `mem_acc_err` low.
- R2: An I/O read accepted at a clock edge gives `io_rvalid` high for exactly the following cycle, with its data on `io_rdata`. An I/O write never produces `io_rvalid`.
- R3: A write to port 0x092 sets `soft_reset_o` to bit 7 of the written byte (mask 0x01) as a level that holds until the next such write. A read of 0x092 returns 0x00.
- R4: A write to 0x092 with bit 6 set (mask 0x02) sets `le_halt_o`. The flag stays high until reset, even if later writes clear that bit.
- R5: Port 0x81C stores every byte written to it, and a read returns the last byte written.
- R6: Port 0x850 stores every byte written to it and reads it back. `noncontig_map_o` equals bit 7 (mask 0x01) of the stored byte.
- R7: Port 0x80C reads the `EQUIP_VAL` parameter (default 0xFF) and port 0x852 reads the `BOARD_ID` parameter (default 0xC0). Writes to either port change nothing.
- R8: Port 0x818 always reads 0x00.
- R9: Writes to ports 0x808, 0x810, 0x812 and 0x814 change no register or output, and reads of these ports return 0xFF.
- R10: Reads of any other port return 0xFF, and writes to other ports are ignored.
- R11: A 32-bit read (`mem_size` = 2) at the word address `PARITY_BASE` (default 0xBFFFEFF0) gives `mem_rvalid` one cycle later with `mem_rdata` = 0.
- R12: Any access in that word with `mem_size` other than 2 pulses `mem_acc_err` one cycle later. A legal word access leaves it low. Accesses outside the word produce neither `mem_rvalid` nor `mem_acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_req_valid | input | 1 | I/O request strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write byte |
| io_rvalid | output | 1 | Read response valid, one cycle after the read |
| io_rdata | output | 8 | Read response byte |
| soft_reset_o | output | 1 | CPU soft-reset level |
| le_halt_o | output | 1 | Sticky halt: unsupported byte order requested |
| noncontig_map_o | output | 1 | Non-contiguous I/O map select |
| mem_req_valid | input | 1 | Memory window request strobe |
| mem_we | input | 1 | Memory write (no effect on data) |
| mem_addr | input | 32 | Memory byte address |
| mem_size | input | 2 | log2 of access bytes (2 = word) |
| mem_rvalid | output | 1 | Memory read response valid |
| mem_rdata | output | 32 | Parity status word (always 0) |
| mem_acc_err | output | 1 | Non-word access pulse |

## Verification
The port decoder is exercised with reads of every mapped class: stored, constant, zero stub and sink. It is also given an unmapped address, and this set separates the 0x00, parameter and 0xFF read results. Writes to sinks, to read-only ports and to unmapped ports are each followed by reads of both stored registers. A write landing on the wrong port would then show up as a changed value. The special port is driven with 0x01, 0x00 and 0x02, then 0x00 again, which separates the soft-reset level from the sticky halt flag. The map port is given bytes that differ only in bit 7 and in the other bits, so a check of the wrong bit is caught. Word, byte and out-of-window memory accesses separate response generation from error signalling.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  localparam int IO_AW   = 16;
  localparam int BYTE_W  = 8;

  // bit n of a port byte is mask 1 << (7 - n)
  function automatic int msb_bit(input int n);
    return BYTE_W - 1 - n;
  endfunction

  localparam int SRST_IDX      = msb_bit(7);
  localparam int LE_IDX        = msb_bit(6);
  localparam int NONCONTIG_IDX = msb_bit(7);

  localparam logic [IO_AW-1:0] P_SPECIAL = 16'h0092;
  localparam logic [IO_AW-1:0] P_EQUIP   = 16'h080C;
  localparam logic [IO_AW-1:0] P_KEYLOCK = 16'h0818;
  localparam logic [IO_AW-1:0] P_SYSCTL  = 16'h081C;
  localparam logic [IO_AW-1:0] P_MAPTYPE = 16'h0850;
  localparam logic [IO_AW-1:0] P_BOARDID = 16'h0852;

  localparam int SINK_N = 4;
  localparam logic [IO_AW-1:0] P_SINKS [SINK_N] =
    '{16'h0808, 16'h0810, 16'h0812, 16'h0814};

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SPECIAL, SEL_EQUIP, SEL_SINK,
    SEL_KEYLOCK, SEL_SYSCTL, SEL_MAPTYPE, SEL_BOARDID
  } port_sel_e;
endpackage

// File: rtl/sysio_port_decode.sv
module sysio_port_decode
  import sysio_pkg::*;
(
  input  logic [IO_AW-1:0] addr,
  output port_sel_e        sel
);
  logic [SINK_N-1:0] sink_hit;

  for (genvar gi = 0; gi < SINK_N; gi++) begin : g_sink
    assign sink_hit[gi] = (addr == P_SINKS[gi]);
  end

  always_comb begin
    sel = SEL_NONE;
    if (|sink_hit)                sel = SEL_SINK;
    else if (addr == P_SPECIAL)   sel = SEL_SPECIAL;
    else if (addr == P_EQUIP)     sel = SEL_EQUIP;
    else if (addr == P_KEYLOCK)   sel = SEL_KEYLOCK;
    else if (addr == P_SYSCTL)    sel = SEL_SYSCTL;
    else if (addr == P_MAPTYPE)   sel = SEL_MAPTYPE;
    else if (addr == P_BOARDID)   sel = SEL_BOARDID;
  end
endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
  import sysio_pkg::*;
#(
  parameter int                DATA_W    = BYTE_W,
  parameter logic [DATA_W-1:0] EQUIP_VAL = 8'hFF,
  parameter logic [DATA_W-1:0] BOARD_ID  = 8'hC0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              we,
  input  port_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_reset_o,
  output logic              le_halt_o,
  output logic              noncontig_o
);
  logic              rd, wr_special, wr_sysctl, wr_map;
  logic [DATA_W-1:0] sysctl_q, maptype_q, rd_mux;

  assign rd         = req_valid && !we;
  assign wr_special = req_valid && we && (sel == SEL_SPECIAL);
  assign wr_sysctl  = req_valid && we && (sel == SEL_SYSCTL);
  assign wr_map     = req_valid && we && (sel == SEL_MAPTYPE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sysctl_q     <= '0;
      maptype_q    <= '0;
      soft_reset_o <= 1'b0;
      le_halt_o    <= 1'b0;
    end else begin
      if (wr_sysctl) sysctl_q  <= wdata;
      if (wr_map)    maptype_q <= wdata;
      if (wr_special) begin
        soft_reset_o <= wdata[SRST_IDX];
        if (wdata[LE_IDX]) le_halt_o <= 1'b1;
      end
    end
  end

  assign noncontig_o = maptype_q[NONCONTIG_IDX];

  always_comb begin
    unique case (sel)
      SEL_SPECIAL: rd_mux = '0;
      SEL_KEYLOCK: rd_mux = '0;
      SEL_EQUIP:   rd_mux = EQUIP_VAL;
      SEL_BOARDID: rd_mux = BOARD_ID;
      SEL_SYSCTL:  rd_mux = sysctl_q;
      SEL_MAPTYPE: rd_mux = maptype_q;
      default:     rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid); // R2
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid); // R2
  AST_SRST_LEVEL: assert property (@(posedge clk) disable iff (rst)
    wr_special |=> soft_reset_o == $past(wdata[SRST_IDX])); // R3
  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_special |=> $stable(soft_reset_o)); // R3
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    le_halt_o |=> le_halt_o); // R4
  AST_SYSCTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_sysctl |=> $stable(sysctl_q)); // R5
  AST_MAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_map |=> noncontig_o == $past(wdata[NONCONTIG_IDX])); // R6
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_map |=> $stable(noncontig_o)); // R6
  AST_KEYLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_KEYLOCK) |=> rdata == '0); // R8
  AST_SINK_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_SINK) |=> rdata == '1); // R9
endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win #(
  parameter int                MEM_AW = 32,
  parameter int                MEM_DW = 32,
  parameter logic [MEM_AW-1:0] BASE   = 32'hBFFF_EFF0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [1:0]        size,
  output logic              rvalid,
  output logic [MEM_DW-1:0] rdata,
  output logic              acc_err
);
  localparam int         LSB_W     = $clog2(MEM_DW / 8);
  localparam logic [1:0] WORD_SIZE = 2'(LSB_W);

  logic hit, bad_size;

  assign hit      = req_valid && (addr[MEM_AW-1:LSB_W] == BASE[MEM_AW-1:LSB_W]);
  assign bad_size = (size != WORD_SIZE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid  <= 1'b0;
      acc_err <= 1'b0;
    end else begin
      rvalid  <= hit && !we;
      acc_err <= hit && bad_size;
    end
  end

  assign rdata = '0;

  AST_ACCERR_RAISED: assert property (@(posedge clk) disable iff (rst)
    (hit && bad_size) |=> acc_err); // R12
  AST_ACCERR_CAUSED: assert property (@(posedge clk) disable iff (rst)
    !(hit && bad_size) |=> !acc_err); // R12
  AST_PARITY_ANSWER: assert property (@(posedge clk) disable iff (rst)
    (hit && !we) |=> rvalid); // R11
  AST_PARITY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !rvalid); // R12
endmodule

// File: rtl/sysio_regblk.sv
module sysio_regblk
  import sysio_pkg::*;
#(
  parameter int                DATA_W      = BYTE_W,
  parameter logic [DATA_W-1:0] EQUIP_VAL   = 8'hFF,
  parameter logic [DATA_W-1:0] BOARD_ID    = 8'hC0,
  parameter int                MEM_AW      = 32,
  parameter int                MEM_DW      = 32,
  parameter logic [MEM_AW-1:0] PARITY_BASE = 32'hBFFF_EFF0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req_valid,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_rvalid,
  output logic [DATA_W-1:0] io_rdata,
  output logic              soft_reset_o,
  output logic              le_halt_o,
  output logic              noncontig_map_o,
  input  logic              mem_req_valid,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [1:0]        mem_size,
  output logic              mem_rvalid,
  output logic [MEM_DW-1:0] mem_rdata,
  output logic              mem_acc_err
);
  port_sel_e sel;

  sysio_port_decode u_dec (.addr(io_addr), .sel(sel));

  sysio_ctrl_regs #(
    .DATA_W(DATA_W), .EQUIP_VAL(EQUIP_VAL), .BOARD_ID(BOARD_ID)
  ) u_regs (
    .clk(clk), .rst(rst), .req_valid(io_req_valid), .we(io_we),
    .sel(sel), .wdata(io_wdata), .rvalid(io_rvalid), .rdata(io_rdata),
    .soft_reset_o(soft_reset_o), .le_halt_o(le_halt_o),
    .noncontig_o(noncontig_map_o)
  );

  sysio_parity_win #(
    .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .BASE(PARITY_BASE)
  ) u_par (
    .clk(clk), .rst(rst), .req_valid(mem_req_valid), .we(mem_we),
    .addr(mem_addr), .size(mem_size), .rvalid(mem_rvalid),
    .rdata(mem_rdata), .acc_err(mem_acc_err)
  );

  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    rst |=> !soft_reset_o && !le_halt_o && !noncontig_map_o && !io_rvalid); // R1
endmodule

// File: tb/test_sysio_regblk.sv
module test_sysio_regblk;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req_valid = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rvalid, soft_reset_o, le_halt_o, noncontig_map_o;
  logic [7:0]  io_rdata;
  logic        mem_req_valid = 1'b0, mem_we = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [1:0]  mem_size = '0;
  logic        mem_rvalid, mem_acc_err;
  logic [31:0] mem_rdata;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysio_regblk i_sysio_regblk (
    .clk(clk), .rst(rst), .io_req_valid(io_req_valid), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rvalid(io_rvalid),
    .io_rdata(io_rdata), .soft_reset_o(soft_reset_o), .le_halt_o(le_halt_o),
    .noncontig_map_o(noncontig_map_o), .mem_req_valid(mem_req_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_acc_err(mem_acc_err)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0092, 8'h00, 8'h00, 4'd3},  // R3 special reads zero
    '{1'b0, 16'h080C, 8'h00, 8'hFF, 4'd7},  // R7 equipment
    '{1'b0, 16'h0852, 8'h00, 8'hC0, 4'd7},  // R7 board id
    '{1'b0, 16'h0818, 8'h00, 8'h00, 4'd8},  // R8 keylock
    '{1'b0, 16'h081C, 8'h00, 8'h00, 4'd1},  // R1 sysctl reset value
    '{1'b0, 16'h0850, 8'h00, 8'h00, 4'd1},  // R1 map type reset value
    '{1'b1, 16'h081C, 8'hA5, 8'h00, 4'd5},
    '{1'b0, 16'h081C, 8'h00, 8'hA5, 4'd5},  // R5
    '{1'b1, 16'h0850, 8'h81, 8'h00, 4'd6},
    '{1'b0, 16'h0850, 8'h00, 8'h81, 4'd6},  // R6
    '{1'b1, 16'h0808, 8'h12, 8'h00, 4'd9},
    '{1'b1, 16'h0810, 8'h34, 8'h00, 4'd9},
    '{1'b1, 16'h0812, 8'h56, 8'h00, 4'd9},
    '{1'b1, 16'h0814, 8'h78, 8'h00, 4'd9},
    '{1'b0, 16'h081C, 8'h00, 8'hA5, 4'd9},  // R9 sinks left sysctl alone
    '{1'b0, 16'h0850, 8'h00, 8'h81, 4'd9},
    '{1'b0, 16'h0808, 8'h00, 8'hFF, 4'd9},
    '{1'b0, 16'h0814, 8'h00, 8'hFF, 4'd9},
    '{1'b0, 16'h0123, 8'h00, 8'hFF, 4'd10}, // R10 unmapped read
    '{1'b1, 16'h0123, 8'h00, 8'h00, 4'd10},
    '{1'b1, 16'h080C, 8'h00, 8'h00, 4'd7},
    '{1'b1, 16'h0852, 8'h11, 8'h00, 4'd7},
    '{1'b0, 16'h080C, 8'h00, 8'hFF, 4'd7},
    '{1'b0, 16'h0852, 8'h00, 8'hC0, 4'd7},
    '{1'b0, 16'h081C, 8'h00, 8'hA5, 4'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic io_op(input logic we, input logic [15:0] a, input logic [7:0] d);
    io_req_valid = 1'b1; io_we = we; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_req_valid = 1'b0; io_we = 1'b0;
  endtask

  task automatic mem_op(input logic we, input logic [31:0] a, input logic [1:0] sz);
    mem_req_valid = 1'b1; mem_we = we; mem_addr = a; mem_size = sz;
    @(negedge clk);
    mem_req_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 soft_reset", soft_reset_o, 0);
    chk("R1 le_halt", le_halt_o, 0);
    chk("R1 noncontig", noncontig_map_o, 0);
    chk("R1 io_rvalid", io_rvalid, 0);
    chk("R1 mem_rvalid", mem_rvalid, 0);
    chk("R1 mem_acc_err", mem_acc_err, 0);

    for (int i = 0; i < NV; i++) begin
      io_op(VECS[i].we, VECS[i].addr, VECS[i].wd);
      if (VECS[i].we) begin
        chk($sformatf("R2 no rvalid on write (R%0d vec %0d)", VECS[i].req, i), io_rvalid, 0);
      end else begin
        chk($sformatf("R2 rvalid (vec %0d)", i), io_rvalid, 1);
        chk($sformatf("R%0d rdata (vec %0d)", VECS[i].req, i), io_rdata, VECS[i].exp);
      end
      chk($sformatf("R9 soft_reset untouched (vec %0d)", i), soft_reset_o, 0);
    end
    @(negedge clk);
    chk("R2 rvalid single cycle", io_rvalid, 0);

    // R3 soft reset level
    io_op(1'b1, 16'h0092, 8'h01);
    chk("R3 soft_reset set", soft_reset_o, 1);
    chk("R4 halt not set by bit 7", le_halt_o, 0);
    repeat (2) @(negedge clk);
    chk("R3 soft_reset held", soft_reset_o, 1);
    io_op(1'b1, 16'h0092, 8'h00);
    chk("R3 soft_reset cleared", soft_reset_o, 0);
    // R4 sticky halt
    io_op(1'b1, 16'h0092, 8'h02);
    chk("R4 halt raised", le_halt_o, 1);
    chk("R3 soft_reset low with mask 0x02", soft_reset_o, 0);
    io_op(1'b1, 16'h0092, 8'h00);
    chk("R4 halt sticky", le_halt_o, 1);

    // R6 map bit position
    io_op(1'b1, 16'h0850, 8'h00);
    chk("R6 map low", noncontig_map_o, 0);
    io_op(1'b1, 16'h0850, 8'hFE);
    chk("R6 other bits ignored", noncontig_map_o, 0);
    io_op(1'b1, 16'h0850, 8'h01);
    chk("R6 map high", noncontig_map_o, 1);
    io_op(1'b1, 16'h0808, 8'hFF);
    chk("R9 sink write leaves map", noncontig_map_o, 1);

    // R11 / R12 parity window
    mem_op(1'b0, 32'hBFFF_EFF0, 2'd2);
    chk("R11 word rvalid", mem_rvalid, 1);
    chk("R11 word rdata", mem_rdata, 0);
    chk("R12 word no error", mem_acc_err, 0);
    mem_op(1'b0, 32'hBFFF_EFF1, 2'd0);
    chk("R12 byte error", mem_acc_err, 1);
    mem_op(1'b1, 32'hBFFF_EFF2, 2'd1);
    chk("R12 half write error", mem_acc_err, 1);
    chk("R12 write no rvalid", mem_rvalid, 0);
    mem_op(1'b0, 32'hBFFF_EFF4, 2'd0);
    chk("R12 outside no rvalid", mem_rvalid, 0);
    chk("R12 outside no error", mem_acc_err, 0);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 halt cleared", le_halt_o, 0);
    chk("R1 map cleared", noncontig_map_o, 0);
    io_op(1'b0, 16'h081C, 8'h00);
    chk("R1 sysctl cleared", io_rdata, 0);

    finish_run();
  end
endmodule